// File: doc/BRIEF.md
# Stream Snapshot Capture Buffer

This block records a snapshot of a valid-qualified stream into an on-chip word buffer so that a host can inspect it over a simple memory-mapped read port. Each accepted beat is reduced to one 32-bit word, taken from a field of the stream picked by a parameter. The words are written at consecutive addresses from zero. When the last location has been written, the buffer freezes, and stream beats are dropped until the buffer is re-armed.

Re-arming follows one of two policies, picked by a parameter. In free-running mode the buffer restarts filling as soon as the host reads the final location. In sync mode that read only releases the buffer, and filling restarts on the next sync pulse of the stream. A write strobe on the control port re-arms the buffer at once in either mode. The sink never stalls the source. A status word reports the full flag, the waiting-for-sync flag and the number of words stored.

Top module: `snap_capture_buf`

## Requirements
- R1: `st_ready` is 1 in every cycle, including during reset.
- R2: Only beats with `st_valid`=1 are stored, at addresses 0, 1, 2, … in arrival order. Beats with `st_valid`=0 occupy no location.
- R3: The stored word depends on `FIELD`. 0 keeps the low 32 bits of `st_data`. 1 keeps `{st_im, st_re}`. 2 keeps `st_re` alone. 3 keeps `st_im` alone. Each is zero-extended, or cut to its low 32 bits when wider.
- R4: Once DEPTH words are stored, `stat[31]` (full) is 1 and the count stays at DEPTH. Further beats, including sync beats, change neither the count nor the stored words.
- R5: A read strobe returns the word at `buf_addr` on `buf_rdata` in the cycle after the strobe. An address of DEPTH or more returns 0. `buf_rdata` holds its value while no read is strobed.
- R6: With `SYNC_START`=0, reading address DEPTH-1 while full clears the full flag and the count in the next cycle. The next valid beat is then stored at address 0.
- R7: With `SYNC_START`=1, the buffer waits after reset, with `stat[30]`=1, and stores nothing until a beat arrives with `st_sync`=1. That beat, if valid, is stored at address 0.
- R8: With `SYNC_START`=1, a sync pulse while full is ignored. Reading address DEPTH-1 while full clears the full flag and returns the buffer to waiting for the next sync.
- R9: `csr_wr`=1 forces a re-arm in the next cycle: count 0, full 0, and `stat[30]` equal to `SYNC_START`. A beat in the same cycle as `csr_wr` is not stored.
- R10: `stat[CW-1:0]` gives the number of words stored since the last re-arm, where CW = clog2(DEPTH+1). The bits of `stat` that carry no flag or count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_data | input | IN_W | Stream data field |
| st_re | input | CPLX_W | Stream real field |
| st_im | input | CPLX_W | Stream imaginary field |
| st_valid | input | 1 | Beat qualifier |
| st_sync | input | 1 | Sync pulse, used when SYNC_START=1 |
| st_ready | output | 1 | Always 1 |
| buf_rd | input | 1 | Buffer read strobe |
| buf_addr | input | ADDR_W | Buffer word address |
| buf_rdata | output | 32 | Read word, valid one cycle after strobe |
| csr_wr | input | 1 | Re-arm command |
| stat | output | 32 | {full, waiting, zeros, count} |

## Verification
The bench builds two instances with DEPTH=8, IN_W=48 and CPLX_W=12, so that fill, freeze and wrap-around all occur within a few dozen beats. The first uses FIELD=0 and SYNC_START=0, and its 48-bit data shows that only the low 32 bits are kept. The second uses FIELD=1 and SYNC_START=1, and its 24-bit im&re value shows zero-extension. The two share one stream but have separate read and control ports. Because of this, sync pulses meant for one instance also test that the other ignores them. With ADDR_W=4, reads at addresses beyond the depth can be issued.

// File: rtl/snap_capture_buf.sv
module snap_capture_buf #(
  parameter int DEPTH      = 1024,
  parameter int ADDR_W     = 11,
  parameter int IN_W       = 32,
  parameter int CPLX_W     = 16,
  parameter int FIELD      = 0,
  parameter bit SYNC_START = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   st_data,
  input  logic [CPLX_W-1:0] st_re,
  input  logic [CPLX_W-1:0] st_im,
  input  logic              st_valid,
  input  logic              st_sync,
  output logic              st_ready,
  input  logic              buf_rd,
  input  logic [ADDR_W-1:0] buf_addr,
  output logic [31:0]       buf_rdata,
  input  logic              csr_wr,
  output logic [31:0]       stat
);
  localparam int MW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);
  localparam logic [CW-1:0] LAST_C = CW'(DEPTH - 1);

  typedef enum logic [1:0] {S_WAIT, S_FILL, S_FULL} state_t;

  state_t      state;
  logic [CW-1:0] count;
  logic [31:0] word;
  logic [31:0] mem [DEPTH];

  generate
    if (FIELD == 1) begin : g_cplx
      logic [2*CPLX_W+31:0] ext;
      assign ext  = {32'd0, st_im, st_re};
      assign word = ext[31:0];
    end else if (FIELD == 2) begin : g_re
      logic [CPLX_W+31:0] ext;
      assign ext  = {32'd0, st_re};
      assign word = ext[31:0];
    end else if (FIELD == 3) begin : g_im
      logic [CPLX_W+31:0] ext;
      assign ext  = {32'd0, st_im};
      assign word = ext[31:0];
    end else begin : g_data
      logic [IN_W+31:0] ext;
      assign ext  = {32'd0, st_data};
      assign word = ext[31:0];
    end
  endgenerate

  wire start   = (state == S_WAIT) && st_sync;
  wire take    = !csr_wr && st_valid && ((state == S_FILL) || start);
  wire [MW-1:0] wr_idx = start ? '0 : count[MW-1:0];
  wire last_rd = buf_rd && (buf_addr == LAST_A) && (state == S_FULL);
  wire in_rng  = (buf_addr <= LAST_A);

  assign st_ready = 1'b1;
  assign stat = {state == S_FULL, state == S_WAIT, {(30-CW){1'b0}}, count};

  always_ff @(posedge clk) begin
    if (take) mem[wr_idx] <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_rdata <= '0;
    else if (buf_rd) buf_rdata <= in_rng ? mem[buf_addr[MW-1:0]] : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SYNC_START ? S_WAIT : S_FILL;
      count <= '0;
    end else if (csr_wr) begin
      state <= SYNC_START ? S_WAIT : S_FILL;
      count <= '0;
    end else begin
      case (state)
        S_WAIT: if (st_sync) begin
          state <= S_FILL;
          count <= st_valid ? CW'(1) : '0;
        end
        S_FILL: if (st_valid) begin
          count <= count + CW'(1);
          if (count == LAST_C) state <= S_FULL;
        end
        S_FULL: if (last_rd) begin
          state <= SYNC_START ? S_WAIT : S_FILL;
          count <= '0;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  p_ready_r1: assert property (@(posedge clk) st_ready == 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FULL && !csr_wr && !last_rd) |=> (state == S_FULL) && $stable(count));

  p_oob_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !in_rng) |=> buf_rdata == 32'd0);

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_rd |=> $stable(buf_rdata));

  p_rearm_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!SYNC_START && last_rd && !csr_wr) |=> (count == '0) && (state == S_FILL));

  p_wait_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !st_sync) |=> count == '0);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (SYNC_START && last_rd && !csr_wr) |=> (state == S_WAIT) && (count == '0));

  p_ctl_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> (count == '0) && (state != S_FULL));
endmodule

// File: tb/tb_snap_capture_buf.sv
module tb_snap_capture_buf;
  localparam int D = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [47:0] st_data = '0;
  logic [11:0] st_re = '0, st_im = '0;
  logic st_valid = 1'b0, st_sync = 1'b0;
  logic rd_a = 1'b0, rd_b = 1'b0, cw_a = 1'b0, cw_b = 1'b0;
  logic [3:0] ad_a = '0, ad_b = '0;
  logic rdy_a, rdy_b;
  logic [31:0] rq_a, rq_b, st_a, st_b;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  snap_capture_buf #(.DEPTH(D), .ADDR_W(4), .IN_W(48), .CPLX_W(12), .FIELD(0), .SYNC_START(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .st_data(st_data), .st_re(st_re), .st_im(st_im),
    .st_valid(st_valid), .st_sync(st_sync), .st_ready(rdy_a), .buf_rd(rd_a),
    .buf_addr(ad_a), .buf_rdata(rq_a), .csr_wr(cw_a), .stat(st_a));

  snap_capture_buf #(.DEPTH(D), .ADDR_W(4), .IN_W(48), .CPLX_W(12), .FIELD(1), .SYNC_START(1'b1)) dut_sync (
    .clk(clk), .rst_n(rst_n), .st_data(st_data), .st_re(st_re), .st_im(st_im),
    .st_valid(st_valid), .st_sync(st_sync), .st_ready(rdy_b), .buf_rd(rd_b),
    .buf_addr(ad_b), .buf_rdata(rq_b), .csr_wr(cw_b), .stat(st_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [47:0] d, input logic [11:0] re, input logic [11:0] im,
                      input logic v, input logic s);
    @(negedge clk);
    st_data = d; st_re = re; st_im = im; st_valid = v; st_sync = s;
    @(negedge clk);
    st_valid = 1'b0; st_sync = 1'b0;
  endtask

  task automatic read_a(input logic [3:0] a, output logic [31:0] q);
    @(negedge clk); rd_a = 1'b1; ad_a = a;
    @(negedge clk); rd_a = 1'b0; q = rq_a;
  endtask

  task automatic read_b(input logic [3:0] a, output logic [31:0] q);
    @(negedge clk); rd_b = 1'b1; ad_b = a;
    @(negedge clk); rd_b = 1'b0; q = rq_b;
  endtask

  task automatic rearm(input bit which_b);
    @(negedge clk);
    if (which_b) cw_b = 1'b1; else cw_a = 1'b1;
    @(negedge clk);
    cw_a = 1'b0; cw_b = 1'b0;
  endtask

  function automatic logic [47:0] pat(input int i);
    return {16'hBEEF, 32'hC0DE_0000 + 32'(i)};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(rdy_a && rdy_b, "R1 ready", {31'd0, rdy_a}, 32'd1);
    chk(st_a == 32'd0, "R10 reset stat free", st_a, 32'd0);
    chk(st_b == 32'h4000_0000, "R7 reset stat sync waits", st_b, 32'h4000_0000);
  endtask

  task automatic t_fill_free();
    logic [31:0] q;
    rearm(1'b0);
    for (int i = 0; i < 3; i++) begin
      beat(pat(i), 12'h0, 12'h0, 1'b1, 1'b0);
      beat(48'hFFFF_FFFF_FFFF, 12'h0, 12'h0, 1'b0, 1'b0);
    end
    chk(st_a == 32'd3, "R10 count after 3 beats", st_a, 32'd3);
    for (int i = 3; i < D; i++) beat(pat(i), 12'h0, 12'h0, 1'b1, 1'b0);
    chk(st_a == 32'h8000_0008, "R4 full with count", st_a, 32'h8000_0008);
    chk(st_b == 32'h4000_0000, "R7 sync instance idle without sync", st_b, 32'h4000_0000);
    beat(48'h1234_5678_9ABC, 12'h0, 12'h0, 1'b1, 1'b0);
    chk(st_a == 32'h8000_0008, "R4 beat ignored when full", st_a, 32'h8000_0008);
    for (int i = 0; i < D - 1; i++) begin
      read_a(4'(i), q);
      chk(q == 32'hC0DE_0000 + 32'(i), "R2 R3 stored low data", q, 32'hC0DE_0000 + 32'(i));
    end
    @(negedge clk);
    chk(rq_a == 32'hC0DE_0006, "R5 rdata holds", rq_a, 32'hC0DE_0006);
    read_a(4'd9, q);
    chk(q == 32'd0, "R5 out of range reads zero", q, 32'd0);
    chk(st_a == 32'h8000_0008, "R6 no rearm before last read", st_a, 32'h8000_0008);
    read_a(4'd7, q);
    chk(q == 32'hC0DE_0007, "R4 last word kept", q, 32'hC0DE_0007);
    chk(st_a == 32'd0, "R6 rearmed after last read", st_a, 32'd0);
    beat(48'h0000_5555_AAAA, 12'h0, 12'h0, 1'b1, 1'b0);
    read_a(4'd0, q);
    chk(q == 32'h5555_AAAA, "R6 restart at address 0", q, 32'h5555_AAAA);
    chk(st_a == 32'd1, "R6 count after restart", st_a, 32'd1);
  endtask

  task automatic t_sync_mode();
    logic [31:0] q;
    rearm(1'b1);
    beat(pat(0), 12'h111, 12'h222, 1'b1, 1'b0);
    chk(st_b == 32'h4000_0000, "R7 no capture before sync", st_b, 32'h4000_0000);
    beat(pat(0), 12'h123, 12'h456, 1'b1, 1'b1);
    chk(st_b == 32'd1, "R7 sync beat stored", st_b, 32'd1);
    for (int i = 1; i < D; i++) beat(pat(0), 12'(i), 12'hA00, 1'b1, 1'b0);
    chk(st_b == 32'h8000_0008, "R4 sync instance full", st_b, 32'h8000_0008);
    beat(pat(0), 12'hFFF, 12'hFFF, 1'b1, 1'b1);
    chk(st_b == 32'h8000_0008, "R8 sync ignored when full", st_b, 32'h8000_0008);
    read_b(4'd0, q);
    chk(q == 32'h0045_6123, "R3 im&re zero extended", q, 32'h0045_6123);
    read_b(4'd7, q);
    chk(q == 32'h00A0_0007, "R8 last word kept", q, 32'h00A0_0007);
    chk(st_b == 32'h4000_0000, "R8 waits after last read", st_b, 32'h4000_0000);
    beat(pat(0), 12'h1, 12'h1, 1'b1, 1'b0);
    chk(st_b == 32'h4000_0000, "R8 no capture until sync", st_b, 32'h4000_0000);
    beat(pat(0), 12'h321, 12'h654, 1'b1, 1'b1);
    chk(st_b == 32'd1, "R8 restart on sync", st_b, 32'd1);
    read_b(4'd0, q);
    chk(q == 32'h0065_4321, "R7 new sync word at 0", q, 32'h0065_4321);
  endtask

  task automatic t_ctl_rearm();
    logic [31:0] q;
    rearm(1'b1);
    chk(st_b == 32'h4000_0000, "R9 sync instance rearm waits", st_b, 32'h4000_0000);
    rearm(1'b0);
    beat(pat(1), 12'h0, 12'h0, 1'b1, 1'b0);
    beat(pat(2), 12'h0, 12'h0, 1'b1, 1'b0);
    chk(st_a == 32'd2, "R10 count two", st_a, 32'd2);
    @(negedge clk);
    cw_a = 1'b1; st_data = 48'h0000_DEAD_0000; st_valid = 1'b1;
    @(negedge clk);
    cw_a = 1'b0; st_valid = 1'b0;
    chk(st_a == 32'd0, "R9 rearm clears count, beat dropped", st_a, 32'd0);
    beat(48'h0000_7777_0001, 12'h0, 12'h0, 1'b1, 1'b0);
    read_a(4'd0, q);
    chk(q == 32'h7777_0001, "R9 capture resumes at 0", q, 32'h7777_0001);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_free();
        t_sync_mode();
        t_ctl_rearm();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule